// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM

This block is a synthesizable behavioural model of a synchronous static RAM. Each word holds 36 bits as four 9-bit lanes. Every control, address and write-data input is captured on the rising clock edge. An access begins when one of two start strobes is asserted with the device selected, and that load takes the external address. Later addresses come from a 2-bit counter that wraps inside an aligned group of four words. The counter moves only when the step input is asserted. The order of those four words is either linear or interleaved, selected by a static input.

Writes can target any combination of lanes through a byte-write qualifier, or all lanes through an all-lanes write input. Read data leaves through an output register, so the read path is pipelined by one extra edge. The output driver is modelled as a data bus plus a drive flag. When the flag is low, the bus reads as zero and stands for the high-impedance state. The output enable acts on the flag with no clock involved.

The sleep input freezes every internal state and floats the output. The array depth is a parameter. When the depth is below the full 18-bit address range, the address wraps modulo the depth.

Top module: `burst_sram`

## Requirements
- R1: A start strobe is accepted only when sel_a_n=0, sel_b=1 and sel_c_n=0. A cycle with start_sec_n=0 while the device is not selected performs no access, writes nothing and ends any burst, so no read data is driven two edges later.
- R2: start_pri_n=0 while the device is not selected has no effect: an active burst continues as if the strobe were absent.
- R3: A cycle accepted through start_pri_n is always a read, even when the write inputs request a write.
- R4: A cycle accepted through start_sec_n loads the address and performs a write if the lane decode requests one, otherwise a read.
- R5: With interleave=0, the two low address bits of a burst are (start + count) mod 4. The count goes up by one on each cycle with step_n=0, and the upper address bits stay fixed.
- R6: With interleave=1, the two low address bits of a burst are start XOR count.
- R7: During an active burst, a cycle with step_n=1 and no start strobe accesses the same address again.
- R8: With byte_wr_n=0 and all_wr_n=1, lane_wr_n[k]=0 writes bits [9k+8:9k] of the word, and the other lanes keep their contents.
- R9: With byte_wr_n=1 and all_wr_n=1, no lane is written and the cycle is a read.
- R10: all_wr_n=0 writes all four lanes, whatever byte_wr_n and lane_wr_n are.
- R11: A read whose address is captured at edge N drives its data, with rd_drive=1, after edge N+1. After a write cycle or an idle cycle, rd_drive is 0 at the matching point.
- R12: out_en_n=1 forces rd_drive to 0 at once, with no clock edge, and rd_data then reads 0.
- R13: While sleep=1, the block ignores all synchronous inputs, keeps the array and pipeline contents, and holds rd_drive at 0. It resumes on the first edge after sleep falls.
- R14: After reset, no burst is active and rd_drive is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 18 | Word address captured by a start strobe |
| din | input | 36 | Write data, four 9-bit lanes |
| sel_a_n | input | 1 | Select, active low |
| sel_b | input | 1 | Select, active high |
| sel_c_n | input | 1 | Select, active low |
| start_pri_n | input | 1 | Primary start strobe, read-only start, ignored when deselected |
| start_sec_n | input | 1 | Secondary start strobe, may write, deselect ends a burst |
| step_n | input | 1 | Advance the burst counter, active low |
| byte_wr_n | input | 1 | Lane-write qualifier, active low |
| lane_wr_n | input | 4 | Per-lane write request, active low |
| all_wr_n | input | 1 | Write all lanes, active low |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| interleave | input | 1 | Burst order: 1 interleaved, 0 linear |
| sleep | input | 1 | Sleep request, active high |
| rd_data | output | 36 | Registered read data, 0 when not driven |
| rd_drive | output | 1 | Output driver active; 0 stands for high impedance |

## Verification
The bench builds the block with DEPTH=16. At that depth, four linear bursts fill the whole array, and a read burst can start from every one of the 16 addresses in both orders. That covers every start offset of the wrap in the linear and interleaved sequences. The small array also lets lane-masked writes, suppressed writes, deselected strobes and sleep cycles be checked against a bench image of the full memory contents.

// File: rtl/burst_sram_pkg.sv
// Package: shared constants and the burst-order function.
// Assumes the burst counter is two bits wide, so a burst spans four words.
package burst_sram_pkg;

    localparam int CNT_W = 2;

    // Low address bits of a burst beat for the selected order.
    function automatic logic [CNT_W-1:0] beat_low(
        input logic [CNT_W-1:0] start,
        input logic [CNT_W-1:0] count,
        input logic             ilv
    );
        return ilv ? (start ^ count) : (start + count);
    endfunction

endpackage

// File: rtl/bsram_seq_ctrl.sv
// Sequencing control: turns the strobes, the select inputs and sleep into
// per-cycle commands (load, step, kill, access).
// Assumes the primary strobe wins over the secondary one in the same cycle.
module bsram_seq_ctrl (
    input  logic sleep,
    input  logic sel_a_n,
    input  logic sel_b,
    input  logic sel_c_n,
    input  logic start_pri_n,
    input  logic start_sec_n,
    input  logic step_n,
    input  logic burst_on,
    output logic pri_start,
    output logic load,
    output logic step,
    output logic kill,
    output logic access
);
    logic selected;
    logic sec_start;
    logic hold;

    // Decode the command for the current cycle.
    always_comb begin
        selected  = !sel_a_n && sel_b && !sel_c_n;
        pri_start = !sleep && !start_pri_n && selected;
        sec_start = !sleep && !pri_start && !start_sec_n && selected;
        kill      = !sleep && !pri_start && !start_sec_n && !selected;
        step      = !sleep && burst_on && !pri_start && start_sec_n && !step_n;
        hold      = !sleep && burst_on && !pri_start && start_sec_n && step_n;
        load      = pri_start || sec_start;
        access    = load || step || hold;
    end

endmodule

// File: rtl/bsram_addr_gen.sv
// Burst address generator: holds the loaded base and the 2-bit count and
// forms the effective address of the current cycle.
// Assumes a frozen cycle (sleep) leaves every register untouched.
module bsram_addr_gen
    import burst_sram_pkg::*;
#(
    parameter int ADDR_W = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              freeze,
    input  logic              load,
    input  logic              step,
    input  logic              kill,
    input  logic              interleave,
    input  logic [ADDR_W-1:0] ext_addr,
    output logic [ADDR_W-1:0] eff_addr,
    output logic              burst_on,
    output logic [CNT_W-1:0]  cnt
);
    logic [ADDR_W-1:0] base_q;
    logic [CNT_W-1:0]  next_cnt;

    // Form the address used by this cycle's access.
    always_comb begin
        next_cnt = step ? cnt + 1'b1 : cnt;
        if (load) begin
            eff_addr = ext_addr;
        end else begin
            eff_addr = {base_q[ADDR_W-1:CNT_W],
                        beat_low(base_q[CNT_W-1:0], next_cnt, interleave)};
        end
    end

    // Track the burst base, the count and whether a burst is active.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q   <= '0;
            cnt      <= '0;
            burst_on <= 1'b0;
        end else if (!freeze) begin
            if (load) begin
                base_q   <= ext_addr;
                cnt      <= '0;
                burst_on <= 1'b1;
            end else if (kill) begin
                burst_on <= 1'b0;
            end else begin
                cnt <= next_cnt;
            end
        end
    end

endmodule

// File: rtl/bsram_lane_dec.sv
// Lane write decode: gives the requested lane mask from the all-lanes
// input, the byte qualifier and the per-lane requests.
// Assumes the all-lanes input takes priority over the qualifier.
module bsram_lane_dec #(
    parameter int N_LANES = 4
) (
    input  logic               all_wr_n,
    input  logic               byte_wr_n,
    input  logic [N_LANES-1:0] lane_wr_n,
    output logic [N_LANES-1:0] lane_en
);
    // One decode per lane.
    for (genvar g = 0; g < N_LANES; g++) begin : g_lane
        assign lane_en[g] = !all_wr_n || (!byte_wr_n && !lane_wr_n[g]);
    end

endmodule

// File: rtl/bsram_core.sv
// Storage array: one memory per lane with its own write enable, and an
// asynchronous read of the whole word.
// Assumes the contents are not reset.
module bsram_core #(
    parameter int DEPTH   = 64,
    parameter int LANE_W  = 9,
    parameter int N_LANES = 4,
    parameter int IDX_W   = 6
) (
    input  logic                      clk,
    input  logic [N_LANES-1:0]        wr_lanes,
    input  logic [IDX_W-1:0]          wr_idx,
    input  logic [N_LANES*LANE_W-1:0] wr_word,
    input  logic [IDX_W-1:0]          rd_idx,
    output logic [N_LANES*LANE_W-1:0] rd_word
);
    for (genvar g = 0; g < N_LANES; g++) begin : g_lane
        logic [LANE_W-1:0] lane_mem [DEPTH];

        // Write this lane when its enable is set.
        always_ff @(posedge clk) begin
            if (wr_lanes[g]) begin
                lane_mem[wr_idx] <= wr_word[g*LANE_W +: LANE_W];
            end
        end

        assign rd_word[g*LANE_W +: LANE_W] = lane_mem[rd_idx];
    end

endmodule

// File: rtl/burst_sram.sv
// Top level: pipelined synchronous burst SRAM. Ties together the control
// decode, the burst address generator, the lane decode, the array and the
// two-stage read pipeline. Output high impedance is shown as rd_drive=0.
// Assumes DEPTH is a power of two; addresses wrap modulo DEPTH.
module burst_sram
    import burst_sram_pkg::*;
#(
    parameter int DEPTH   = 64,
    parameter int LANE_W  = 9,
    parameter int N_LANES = 4,
    parameter int ADDR_W  = 18
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [ADDR_W-1:0]         addr,
    input  logic [N_LANES*LANE_W-1:0] din,
    input  logic                      sel_a_n,
    input  logic                      sel_b,
    input  logic                      sel_c_n,
    input  logic                      start_pri_n,
    input  logic                      start_sec_n,
    input  logic                      step_n,
    input  logic                      byte_wr_n,
    input  logic [N_LANES-1:0]        lane_wr_n,
    input  logic                      all_wr_n,
    input  logic                      out_en_n,
    input  logic                      interleave,
    input  logic                      sleep,
    output logic [N_LANES*LANE_W-1:0] rd_data,
    output logic                      rd_drive
);
    localparam int WORD_W = N_LANES * LANE_W;
    localparam int IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic               pri_start, load, step, kill, access;
    logic               burst_on;
    logic [CNT_W-1:0]   cnt;
    logic [ADDR_W-1:0]  eff_addr;
    logic [N_LANES-1:0] lane_en, wr_lanes;
    logic               wr_any, is_read;
    logic [IDX_W-1:0]   cur_idx, rd_idx;
    logic [WORD_W-1:0]  rd_word, q_reg;
    logic               rd_pend, out_valid;

    bsram_seq_ctrl u_ctrl (
        .sleep       (sleep),
        .sel_a_n     (sel_a_n),
        .sel_b       (sel_b),
        .sel_c_n     (sel_c_n),
        .start_pri_n (start_pri_n),
        .start_sec_n (start_sec_n),
        .step_n      (step_n),
        .burst_on    (burst_on),
        .pri_start   (pri_start),
        .load        (load),
        .step        (step),
        .kill        (kill),
        .access      (access)
    );

    bsram_addr_gen #(.ADDR_W(ADDR_W)) u_agen (
        .clk        (clk),
        .rst_n      (rst_n),
        .freeze     (sleep),
        .load       (load),
        .step       (step),
        .kill       (kill),
        .interleave (interleave),
        .ext_addr   (addr),
        .eff_addr   (eff_addr),
        .burst_on   (burst_on),
        .cnt        (cnt)
    );

    bsram_lane_dec #(.N_LANES(N_LANES)) u_ldec (
        .all_wr_n  (all_wr_n),
        .byte_wr_n (byte_wr_n),
        .lane_wr_n (lane_wr_n),
        .lane_en   (lane_en)
    );

    // A primary start suppresses writes; otherwise an access writes when any
    // lane is requested.
    always_comb begin
        wr_lanes = (access && !pri_start) ? lane_en : '0;
        wr_any   = |wr_lanes;
        is_read  = access && !wr_any;
        cur_idx  = IDX_W'(eff_addr % ADDR_W'(DEPTH));
    end

    bsram_core #(
        .DEPTH   (DEPTH),
        .LANE_W  (LANE_W),
        .N_LANES (N_LANES),
        .IDX_W   (IDX_W)
    ) u_core (
        .clk      (clk),
        .wr_lanes (wr_lanes),
        .wr_idx   (cur_idx),
        .wr_word  (din),
        .rd_idx   (rd_idx),
        .rd_word  (rd_word)
    );

    // Read pipeline: capture the index, then register the data one edge later.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_pend   <= 1'b0;
            rd_idx    <= '0;
            out_valid <= 1'b0;
            q_reg     <= '0;
        end else if (!sleep) begin
            rd_pend   <= is_read;
            rd_idx    <= cur_idx;
            out_valid <= rd_pend;
            if (rd_pend) begin
                q_reg <= rd_word;
            end
        end
    end

    // Output gating: enable and sleep act without a clock.
    always_comb begin
        rd_drive = out_valid && !out_en_n && !sleep;
        rd_data  = rd_drive ? q_reg : '0;
    end

endmodule

// File: rtl/burst_sram_chk.sv
// Checker: temporal properties of the burst SRAM, bound into every instance.
// Assumes the burst counter is two bits wide.
module bsram_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       sleep,
    input logic       start_pri_n,
    input logic       start_sec_n,
    input logic       step_n,
    input logic       sel_a_n,
    input logic       sel_b,
    input logic       sel_c_n,
    input logic       all_wr_n,
    input logic       byte_wr_n,
    input logic       burst_on,
    input logic [1:0] cnt,
    input logic       wr_any,
    input logic       rd_pend,
    input logic       out_valid
);
    p_pri_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep && !start_pri_n && !sel_a_n && sel_b && !sel_c_n) |-> !wr_any);

    p_no_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (all_wr_n && byte_wr_n) |-> !wr_any);

    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_on && !sleep && start_pri_n && start_sec_n && step_n)
        |=> ($stable(cnt) && burst_on));

    p_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_on && !sleep && start_pri_n && start_sec_n && !step_n)
        |=> (cnt == $past(cnt) + 2'd1));

    p_frozen_r13: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |=> ($stable(cnt) && $stable(burst_on) && $stable(out_valid)));

    p_pipe_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_pend && !sleep) |=> out_valid);

    p_write_no_read_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_any && !sleep) |=> !rd_pend);

    p_desel_end_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep && start_pri_n && !start_sec_n && !sel_b) |=> !burst_on);

    p_reset_r14: assert property (@(posedge clk)
        !rst_n |=> (!burst_on && !out_valid && !rd_pend));

endmodule

bind burst_sram bsram_checker u_chk (.*);

// File: tb/burst_sram_tb.sv
module burst_sram_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 16;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [17:0] addr;
    logic [35:0] din;
    logic        sel_a_n, sel_b, sel_c_n;
    logic        start_pri_n, start_sec_n, step_n;
    logic        byte_wr_n, all_wr_n, out_en_n, interleave, sleep;
    logic [3:0]  lane_wr_n;
    logic [35:0] rd_data;
    logic        rd_drive;

    int n_chk = 0;
    int n_err = 0;

    // Bench image of the burst state, the memory and the read pipeline.
    logic        m_on;
    logic [17:0] m_base;
    logic [1:0]  m_cnt;
    logic        pend_v;
    logic [35:0] pend_d;
    logic [35:0] mref [DEPTH];

    always #(CLK_PERIOD/2) clk = ~clk;

    burst_sram #(.DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .din(din),
        .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n),
        .start_pri_n(start_pri_n), .start_sec_n(start_sec_n), .step_n(step_n),
        .byte_wr_n(byte_wr_n), .lane_wr_n(lane_wr_n), .all_wr_n(all_wr_n),
        .out_en_n(out_en_n), .interleave(interleave), .sleep(sleep),
        .rd_data(rd_data), .rd_drive(rd_drive)
    );

    function automatic logic [35:0] pat(input int a);
        logic [35:0] v;
        v = 36'(a) * 36'h0_0F0F_1357;
        return v ^ 36'hA_5A5A_5A5A;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [35:0] act,
                       input logic [35:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        sel_a_n = 1'b0; sel_b = 1'b1; sel_c_n = 1'b0;
        start_pri_n = 1'b1; start_sec_n = 1'b1; step_n = 1'b1;
        byte_wr_n = 1'b1; lane_wr_n = 4'hF; all_wr_n = 1'b1;
        out_en_n = 1'b0; sleep = 1'b0;
    endtask

    // One clock cycle: predict from the driven inputs, clock, then check the
    // output produced by the read of the previous cycle.
    task automatic tick(input string req);
        logic        sel, acc, rd;
        logic [3:0]  m;
        logic [17:0] eff;
        logic [35:0] rdd;
        sel = !sel_a_n && sel_b && !sel_c_n;
        acc = 1'b0; rd = 1'b0; rdd = '0; eff = '0;
        m = !all_wr_n ? 4'hF : (!byte_wr_n ? ~lane_wr_n : 4'h0);
        if (!sleep) begin
            if (!start_pri_n && sel) begin
                m_on = 1'b1; m_base = addr; m_cnt = 2'd0; acc = 1'b1; m = 4'h0;
            end else if (!start_sec_n) begin
                if (sel) begin
                    m_on = 1'b1; m_base = addr; m_cnt = 2'd0; acc = 1'b1;
                end else begin
                    m_on = 1'b0;
                end
            end else if (m_on) begin
                if (!step_n) m_cnt = m_cnt + 2'd1;
                acc = 1'b1;
            end
            eff = {m_base[17:2], interleave ? (m_base[1:0] ^ m_cnt)
                                            : (m_base[1:0] + m_cnt)};
            if (!acc) m = 4'h0;
            rd  = acc && (m == 4'h0);
            rdd = mref[eff[3:0]];
        end
        @(posedge clk);
        @(negedge clk);
        if (sleep) begin
            chk(rd_drive == 1'b0, {req, " sleep float"}, 36'(rd_drive), 36'd0);
        end else begin
            chk(rd_drive == (pend_v && !out_en_n), {req, " drive"},
                36'(rd_drive), 36'(pend_v && !out_en_n));
            if (pend_v && !out_en_n)
                chk(rd_data == pend_d, {req, " data"}, rd_data, pend_d);
            for (int b = 0; b < 4; b++)
                if (m[b]) mref[eff[3:0]][b*9 +: 9] = din[b*9 +: 9];
            pend_v = rd;
            pend_d = rdd;
        end
    endtask

    task automatic deselect(input string req);
        start_sec_n = 1'b0; sel_a_n = 1'b1;
        tick(req);
        idle_inputs();
        tick(req);
    endtask

    // Watchdog: a hung run is a failed check.
    initial begin
        #(CLK_PERIOD * 100000);
        n_err++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        m_on = 1'b0; m_base = '0; m_cnt = '0; pend_v = 1'b0; pend_d = '0;
        for (int i = 0; i < DEPTH; i++) mref[i] = '0;
        addr = '0; din = '0; interleave = 1'b0;
        idle_inputs();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R14: nothing driven after reset
        chk(rd_drive == 1'b0, "R14 reset drive", 36'(rd_drive), 36'd0);
        tick("R14");

        // R4 R10 R5: fill the array with linear bursts, all lanes written
        for (int b = 0; b < DEPTH; b += 4) begin
            addr = 18'(b); start_sec_n = 1'b0; all_wr_n = 1'b0; din = pat(b);
            byte_wr_n = 1'b1; lane_wr_n = 4'hF;
            tick("R4");
            start_sec_n = 1'b1;
            for (int k = 1; k < 4; k++) begin
                step_n = 1'b0; din = pat(b + k);
                tick("R10");
            end
            idle_inputs();
        end
        deselect("R1");

        // R3 R5 R6 R11: read bursts from every start in both orders
        for (int md = 0; md < 2; md++) begin
            interleave = md[0];
            for (int s = 0; s < DEPTH; s++) begin
                addr = 18'(s); start_pri_n = 1'b0; all_wr_n = s[0]; din = '0;
                tick("R3");
                start_pri_n = 1'b1; all_wr_n = 1'b1;
                for (int k = 1; k < 4; k++) begin
                    step_n = 1'b0;
                    tick(md == 1 ? "R6" : "R5");
                end
                step_n = 1'b1;
            end
            deselect("R11");
        end
        interleave = 1'b0;

        // R8: lane-masked writes, then hold reads of the same word (R7)
        addr = 18'd5; start_sec_n = 1'b0; byte_wr_n = 1'b0; lane_wr_n = 4'b1010;
        din = ~pat(5);
        tick("R8");
        idle_inputs();
        tick("R8");
        tick("R7");
        tick("R8");
        addr = 18'd9; start_sec_n = 1'b0; byte_wr_n = 1'b0; lane_wr_n = 4'b0101;
        din = ~pat(9);
        tick("R8");
        idle_inputs();
        tick("R8");
        tick("R8");
        // R9: qualifier high, no write, the cycle reads
        addr = 18'd6; start_sec_n = 1'b0; byte_wr_n = 1'b1; lane_wr_n = 4'h0;
        din = '0;
        tick("R9");
        idle_inputs();
        tick("R9");
        tick("R9");

        // R2: primary strobe while deselected is ignored
        addr = 18'd8; start_sec_n = 1'b0;
        tick("R2");
        idle_inputs();
        addr = 18'd2; start_pri_n = 1'b0; sel_a_n = 1'b1;
        tick("R2");
        idle_inputs();
        step_n = 1'b0;
        tick("R2");
        idle_inputs();
        tick("R2");
        tick("R2");

        // R1: secondary strobe while deselected ends the burst and writes nothing
        addr = 18'd3; start_sec_n = 1'b0; sel_b = 1'b0; all_wr_n = 1'b0;
        din = '0;
        tick("R1");
        idle_inputs();
        tick("R1");
        tick("R1");
        addr = 18'd3; start_pri_n = 1'b0;
        tick("R1");
        idle_inputs();
        tick("R1");
        tick("R1");

        // R12: output enable acts without a clock
        out_en_n = 1'b1;
        #1;
        chk(rd_drive == 1'b0, "R12 enable off", 36'(rd_drive), 36'd0);
        chk(rd_data == '0, "R12 data zero", rd_data, 36'd0);
        out_en_n = 1'b0;
        #1;
        chk(rd_drive == 1'b1, "R12 enable on", 36'(rd_drive), 36'd1);
        chk(rd_data == mref[3], "R12 data", rd_data, mref[3]);
        deselect("R12");

        // R13: sleep freezes everything and ignores a write request
        addr = 18'd10; start_pri_n = 1'b0;
        tick("R13");
        idle_inputs();
        step_n = 1'b0;
        tick("R13");
        sleep = 1'b1;
        #1;
        chk(rd_drive == 1'b0, "R13 float", 36'(rd_drive), 36'd0);
        addr = 18'd0; start_sec_n = 1'b0; all_wr_n = 1'b0; din = '0;
        tick("R13");
        tick("R13");
        idle_inputs();
        step_n = 1'b0;
        tick("R13");
        idle_inputs();
        tick("R13");
        addr = 18'd0; start_pri_n = 1'b0;
        tick("R13");
        idle_inputs();
        tick("R13");
        deselect("R13");
        tick("R11");

        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule